// File: doc/BRIEF.md
# Cascaded Programmable Clock Channel Divider

This block produces one divided clock channel from a fast input clock by passing it through two divider stages in series. Each stage has its own low-cycle count, high-cycle count, phase offset, starting level and bypass bit. The first stage advances on every input clock cycle. The second stage advances once per output period of the first stage. The output is given both as a level waveform (`div_level`) and as a one-cycle enable pulse (`div_tick`) at each rising edge of that waveform, so downstream logic can use either form.

A chip-level synchronous `sync` input restarts every stage. This lets several channels share a common alignment point. A channel can be set to ignore `sync`. In that mode `sync` instead mutes the channel to a static level chosen by the force bit, and the counters keep running. New counts are picked up at a period boundary or during a restart, so a configuration write can never produce a runt pulse.

Each stage is a four-state machine:

- `ST_SYNC`: the restart and park state. It is entered on reset, while `sync` is obeyed, and while the stage is bypassed.
- `ST_DELAY`: the stage counts out its phase offset.
- `ST_HIGH` and `ST_LOW`: the two output phases.

The transitions are:

- Restart exit: `ST_SYNC` goes to `ST_DELAY` when the offset is non-zero. Otherwise it goes straight to the start phase.
- Delay done: `ST_DELAY` goes to the start phase.
- Fall: `ST_HIGH` goes to `ST_LOW`.
- Rise: `ST_LOW` goes to `ST_HIGH`.
- Forced return: any state goes to `ST_SYNC` on an obeyed `sync` or on bypass.

Top module: `clkdiv_chain`

## Requirements
- R1: A stage set to low count M and high count N (4 bits each) holds its output low for M+1 input enables and high for N+1 input enables, which gives a period of M+N+2.
- R2: With the start bit at 1, a stage shows a high level while restarting and begins with its high phase. With the start bit at 0, it shows a low level and begins with its low phase.
- R3: While `sync` is high and `cfg_nosync` is 0, every stage is held in restart. The output sits at the start level and `div_tick` stays 0, unless all stages are bypassed.
- R4: After `sync` falls, a stage waits for P input enables (P is its 4-bit phase offset) before its first phase begins. For stage 0 starting low, the output is low for P+M+1 cycles after the first clock edge that samples `sync` low.
- R5: Stage 1 advances only on rising edges of stage 0. The channel period is therefore (M0+N0+2)·(M1+N1+2) cycles, with a high time of (N1+1)·(M0+N0+2).
- R6: A bypassed stage passes its input enable and level straight through. When both stages are bypassed, `div_tick` is 1 on every cycle and `div_level` is 1.
- R7: Changes to M and N made during a period have no effect until the next period start. The phase in progress completes with its old count.
- R8: When `cfg_nosync` is 1, `sync` does not restart the stages. While `sync` is high, `div_level` equals `cfg_force_hi` and `div_tick` is 0.
- R9: When `cfg_nosync` is 0, `cfg_force_hi` has no effect on the output.
- R10: While `rst_n` is low, `div_tick` is 0 and `div_level` is at the start level of the last non-bypassed stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Chip-level restart, level sensitive, synchronous to `clk` |
| cfg_low | input | STAGES*CNT_W | Low-cycle count per stage; stage k at bits [k*CNT_W +: CNT_W] |
| cfg_high | input | STAGES*CNT_W | High-cycle count per stage |
| cfg_phase | input | STAGES*CNT_W | Phase offset per stage, in that stage's input enables |
| cfg_start_hi | input | STAGES | Per-stage start level (1 = high) |
| cfg_bypass | input | STAGES | Per-stage bypass and park |
| cfg_nosync | input | 1 | 1 = ignore `sync` for restart |
| cfg_force_hi | input | 1 | Static output level used while `sync` is ignored and asserted |
| div_level | output | 1 | Divided output waveform |
| div_tick | output | 1 | One-cycle pulse on each rising edge of the divided output |

## Verification
The assertions assume that `sync`, `cfg_nosync` and `cfg_bypass` change only synchronously to `clk` and are quasi-static relative to the checked windows. They also assume that the counters are checked only after a reset has placed every stage in `ST_SYNC`. The stimulus changes every input at the falling edge of the clock and asserts reset before any measurement. It writes count fields only at a restart or, in the update test, at a sampled point inside a phase. Run lengths are measured from the second run after a restart, so the partial first run after release never affects the period checks.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_SYNC  = 2'd0,
        ST_DELAY = 2'd1,
        ST_HIGH  = 2'd2,
        ST_LOW   = 2'd3
    } stage_state_e;

endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             en_in,
    input  logic             lvl_in,
    input  logic [CNT_W-1:0] cfg_low,
    input  logic [CNT_W-1:0] cfg_high,
    input  logic [CNT_W-1:0] cfg_phase,
    input  logic             cfg_start_hi,
    input  logic             cfg_bypass,
    output logic             en_out,
    output logic             lvl_out
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    stage_state_e     state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [CNT_W-1:0] low_q, high_q;
    logic             start_q;
    logic             load_cnt, load_start, rise;
    logic             lvl_int;

    // next-state and counter logic
    always_comb begin
        state_n    = state;
        cnt_n      = cnt;
        load_cnt   = 1'b0;
        load_start = 1'b0;
        rise       = 1'b0;
        if (cfg_bypass) begin
            state_n = ST_SYNC;
            cnt_n   = CNT_ZERO;
        end else if (hold) begin
            state_n = ST_SYNC;
            cnt_n   = CNT_ZERO;
        end else begin
            unique case (state)
                ST_SYNC: begin
                    load_cnt   = 1'b1;
                    load_start = 1'b1;
                    if (cfg_phase == CNT_ZERO) begin
                        state_n = cfg_start_hi ? ST_HIGH : ST_LOW;
                        cnt_n   = cfg_start_hi ? cfg_high : cfg_low;
                    end else begin
                        state_n = ST_DELAY;
                        cnt_n   = cfg_phase - CNT_ONE;
                    end
                end
                ST_DELAY: begin
                    if (en_in) begin
                        if (cnt == CNT_ZERO) begin
                            state_n = start_q ? ST_HIGH : ST_LOW;
                            cnt_n   = start_q ? high_q : low_q;
                        end else begin
                            cnt_n = cnt - CNT_ONE;
                        end
                    end
                end
                ST_HIGH: begin
                    if (en_in) begin
                        if (cnt == CNT_ZERO) begin
                            state_n = ST_LOW;
                            if (!start_q) begin
                                load_cnt = 1'b1;
                                cnt_n    = cfg_low;
                            end else begin
                                cnt_n = low_q;
                            end
                        end else begin
                            cnt_n = cnt - CNT_ONE;
                        end
                    end
                end
                ST_LOW: begin
                    if (en_in) begin
                        if (cnt == CNT_ZERO) begin
                            state_n = ST_HIGH;
                            rise    = 1'b1;
                            if (start_q) begin
                                load_cnt = 1'b1;
                                cnt_n    = cfg_high;
                            end else begin
                                cnt_n = high_q;
                            end
                        end else begin
                            cnt_n = cnt - CNT_ONE;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_SYNC;
            cnt     <= CNT_ZERO;
            low_q   <= CNT_ZERO;
            high_q  <= CNT_ZERO;
            start_q <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (load_cnt) begin
                low_q  <= cfg_low;
                high_q <= cfg_high;
            end
            if (load_start) begin
                start_q <= cfg_start_hi;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_SYNC:  lvl_int = cfg_start_hi;
            ST_DELAY: lvl_int = start_q;
            ST_HIGH:  lvl_int = 1'b1;
            ST_LOW:   lvl_int = 1'b0;
        endcase
        en_out  = cfg_bypass ? en_in  : rise;
        lvl_out = cfg_bypass ? lvl_in : lvl_int;
    end

    // R1: a running phase never holds more than its latched count
    a_r1_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW) |-> (cnt <= low_q));
    a_r1_high_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> (cnt <= high_q));
    // R1: an emitted rising-edge enable is followed by the high phase
    a_r1_tick_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_bypass && en_out) |=> (state == ST_HIGH));
    // R6: a bypassed stage is parked in restart
    a_r6_bypass_parked: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bypass |=> (state == ST_SYNC));
    // R4: the level is steady through the offset wait
    a_r4_delay_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && $past(state) == ST_DELAY) |-> $stable(lvl_int));

endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out (
    input  logic lvl_in,
    input  logic tick_in,
    input  logic sync,
    input  logic nosync,
    input  logic force_hi,
    output logic div_level,
    output logic div_tick
);

    logic muted;

    always_comb begin
        muted     = sync & nosync;
        div_level = muted ? force_hi : lvl_in;
        div_tick  = tick_in & ~muted;
    end

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
    import clkdiv_pkg::*;
#(
    parameter int STAGES = 2,
    parameter int CNT_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sync,
    input  logic [STAGES*CNT_W-1:0]   cfg_low,
    input  logic [STAGES*CNT_W-1:0]   cfg_high,
    input  logic [STAGES*CNT_W-1:0]   cfg_phase,
    input  logic [STAGES-1:0]         cfg_start_hi,
    input  logic [STAGES-1:0]         cfg_bypass,
    input  logic                      cfg_nosync,
    input  logic                      cfg_force_hi,
    output logic                      div_level,
    output logic                      div_tick
);

    logic [STAGES:0] en_chain;
    logic [STAGES:0] lvl_chain;
    logic            hold;

    assign hold         = sync & ~cfg_nosync;
    assign en_chain[0]  = 1'b1;
    assign lvl_chain[0] = 1'b1;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        clkdiv_stage #(
            .CNT_W(CNT_W)
        ) u_stage (
            .clk          (clk),
            .rst_n        (rst_n),
            .hold         (hold),
            .en_in        (en_chain[k]),
            .lvl_in       (lvl_chain[k]),
            .cfg_low      (cfg_low[k*CNT_W +: CNT_W]),
            .cfg_high     (cfg_high[k*CNT_W +: CNT_W]),
            .cfg_phase    (cfg_phase[k*CNT_W +: CNT_W]),
            .cfg_start_hi (cfg_start_hi[k]),
            .cfg_bypass   (cfg_bypass[k]),
            .en_out       (en_chain[k+1]),
            .lvl_out      (lvl_chain[k+1])
        );
    end

    clkdiv_out u_out (
        .lvl_in    (lvl_chain[STAGES]),
        .tick_in   (en_chain[STAGES]),
        .sync      (sync),
        .nosync    (cfg_nosync),
        .force_hi  (cfg_force_hi),
        .div_level (div_level),
        .div_tick  (div_tick)
    );

    // R3: an obeyed restart silences the edge pulse unless every stage is bypassed
    a_r3_sync_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !cfg_nosync && !(&cfg_bypass)) |-> !div_tick);
    // R8: a muted channel emits no edge pulse
    a_r8_mute_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && cfg_nosync) |-> !div_tick);

endmodule

// File: tb/clkdiv_chain_test.sv
`timescale 1ns/1ps
module clkdiv_chain_test;

    localparam int ST = 2;
    localparam int CW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sync = 1'b0;
    logic [ST*CW-1:0] cfg_low = '0, cfg_high = '0, cfg_phase = '0;
    logic [ST-1:0]   cfg_start_hi = '0, cfg_bypass = '0;
    logic            cfg_nosync = 1'b0, cfg_force_hi = 1'b0;
    logic            div_level, div_tick;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clkdiv_chain #(.STAGES(ST), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .sync(sync),
        .cfg_low(cfg_low), .cfg_high(cfg_high), .cfg_phase(cfg_phase),
        .cfg_start_hi(cfg_start_hi), .cfg_bypass(cfg_bypass),
        .cfg_nosync(cfg_nosync), .cfg_force_hi(cfg_force_hi),
        .div_level(div_level), .div_tick(div_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_stage(input int k, input int m, input int n, input int off,
                             input bit st, input bit byp);
        cfg_low[k*CW +: CW]   = CW'(m);
        cfg_high[k*CW +: CW]  = CW'(n);
        cfg_phase[k*CW +: CW] = CW'(off);
        cfg_start_hi[k]       = st;
        cfg_bypass[k]         = byp;
    endtask

    // raise sync for a few cycles, drop it; returns at the negedge after the release edge
    task automatic restart();
        @(negedge clk);
        sync = 1'b1;
        repeat (3) @(negedge clk);
        sync = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_level(input bit v);
        for (int i = 0; i < 4000 && div_level != v; i++) @(negedge clk);
    endtask

    task automatic run_len(input bit v, output int n);
        n = 0;
        while (div_level == v && n < 4000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        set_stage(0, 2, 1, 0, 1'b0, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 level in reset", int'(div_level), 0);
        check("R10 tick in reset", int'(div_tick), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_divide(input int m, input int n);
        int h, l;
        set_stage(0, m, n, 0, 1'b0, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        restart();
        wait_level(1'b1);
        wait_level(1'b0);
        wait_level(1'b1);
        run_len(1'b1, h);
        run_len(1'b0, l);
        check($sformatf("R1 high run M=%0d N=%0d", m, n), h, n + 1);
        check($sformatf("R1 low run M=%0d N=%0d", m, n), l, m + 1);
    endtask

    task automatic t_start_high();
        int h;
        set_stage(0, 3, 2, 0, 1'b1, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        @(negedge clk);
        sync = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 start-high level in restart", int'(div_level), 1);
        sync = 1'b0;
        @(negedge clk);
        run_len(1'b1, h);
        check("R2 first phase high width", h, 3);
    endtask

    task automatic t_phase(input int off);
        int l;
        set_stage(0, 2, 1, off, 1'b0, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        restart();
        run_len(1'b0, l);
        check($sformatf("R4 low time after release offset=%0d", off), l, off + 3);
    endtask

    task automatic t_sync_hold();
        int ticks = 0;
        set_stage(0, 0, 0, 0, 1'b0, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        cfg_force_hi = 1'b1;
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            if (div_tick) ticks++;
            @(negedge clk);
        end
        check("R3 no tick while restarting", ticks, 0);
        check("R9 force ignored while sync obeyed", int'(div_level), 0);
        sync = 1'b0;
        cfg_force_hi = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_cascade();
        int h, l;
        set_stage(0, 1, 0, 0, 1'b0, 1'b0);
        set_stage(1, 1, 2, 0, 1'b0, 1'b0);
        restart();
        wait_level(1'b1);
        wait_level(1'b0);
        wait_level(1'b1);
        run_len(1'b1, h);
        run_len(1'b0, l);
        check("R5 cascaded high width", h, 9);
        check("R5 cascaded period", h + l, 15);
    endtask

    task automatic t_bypass();
        int ones = 0, lv = 0, h, l;
        set_stage(0, 0, 0, 0, 1'b0, 1'b1);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        restart();
        for (int i = 0; i < 8; i++) begin
            if (div_tick) ones++;
            if (div_level) lv++;
            @(negedge clk);
        end
        check("R6 full-rate tick with both bypassed", ones, 8);
        check("R6 level high with both bypassed", lv, 8);
        set_stage(1, 3, 2, 0, 1'b0, 1'b0);
        restart();
        wait_level(1'b1);
        wait_level(1'b0);
        run_len(1'b0, l);
        run_len(1'b1, h);
        check("R6 stage0 bypassed low run", l, 4);
        check("R6 stage0 bypassed high run", h, 3);
    endtask

    task automatic t_update();
        int a, b, c;
        set_stage(0, 2, 4, 0, 1'b0, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        restart();
        wait_level(1'b1);
        cfg_low[CW-1:0]  = CW'(6);
        cfg_high[CW-1:0] = CW'(1);
        run_len(1'b1, a);
        run_len(1'b0, b);
        run_len(1'b1, c);
        check("R7 phase in progress keeps old count", a, 5);
        check("R7 new low count at period start", b, 7);
        check("R7 new high count", c, 2);
    endtask

    task automatic t_nosync();
        int ticks = 0;
        set_stage(0, 5, 5, 0, 1'b0, 1'b0);
        set_stage(1, 0, 0, 0, 1'b0, 1'b1);
        restart();
        cfg_nosync = 1'b1;
        cfg_force_hi = 1'b1;
        @(negedge clk);
        sync = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            if (div_tick) ticks++;
            if (i == 3) check("R8 forced high while muted", int'(div_level), 1);
            if (i == 9) begin
                cfg_force_hi = 1'b0;
            end
            if (i == 11) check("R8 forced low while muted", int'(div_level), 0);
        end
        check("R8 no tick while muted", ticks, 0);
        sync = 1'b0;
        cfg_nosync = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_divide(2, 1);
        t_divide(0, 0);
        t_divide(5, 3);
        t_divide(15, 15);
        t_start_high();
        t_phase(0);
        t_phase(3);
        t_sync_hold();
        t_cascade();
        t_bypass();
        t_update();
        t_nosync();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule